// File: doc/BRIEF.md
# Directory Coherence Home Agent

This block serves read and release requests from a small set of caching agents for one slice of physical memory. For every line in its slice it holds a directory entry: a 2-bit state (Invalid, Shared, Exclusive) and a presence vector with one bit per agent. When a read arrives, the entry decides whether any other agent must be snooped. Only the agent the entry lists as the exclusive holder is ever snooped, and no message is broadcast. The line is then fetched from a built-in memory-controller model and returned to the requester as two beats, each holding half of a 128-byte line. The directory entry is updated, and a completion reports the line's resulting state.

Requests enter on a valid/ready channel carrying agent number, opcode and line index. Snoops, data beats and completions leave on three separate valid-only channels. Snoop responses come back on their own input. One transaction is in flight at a time, so a request to a line that is busy waits with ready low until the line is free again.

Top module: `hm_home_agent`

## Requirements
- R1: After reset every directory entry is Invalid with an empty presence vector; `req_ready_o` is 1 and `snp_valid_o`, `dat_valid_o`, `cpl_valid_o` are 0.
- R2: A read (opcode 0, or any code other than 1) to an Invalid line issues no snoop. The line becomes Exclusive (state code 2) with only the requester's presence bit set.
- R3: A read to a Shared line (state code 1) issues no snoop. The line stays Shared, and the requester's bit is added to the presence vector.
- R4: A read to a line held Exclusive by another agent issues exactly one snoop, with `snp_tgt_o` equal to the one-hot bit of that holder. The agent then waits for a snoop response whose agent field names the holder; responses naming any other agent are ignored. After that the line becomes Shared with both agents present.
- R5: A read by the agent that already holds the line Exclusive issues no snoop, and the entry is unchanged (state stays 2).
- R6: A snoop never targets an agent whose presence bit is clear in the line's entry.
- R7: Every read returns exactly two beats to the requester, beat index 0 and then 1. The data of beat b of line a is ((2a+b)+1) * 0x9E3779B1, taken modulo 2^DATA_W.
- R8: `req_ready_o` is 0 from the cycle after a request is accepted until the cycle after its completion.
- R9: A release (opcode 1) clears the requester's presence bit. The state becomes Invalid if no bit remains and is kept otherwise. A release from an agent whose bit is clear leaves the entry unchanged. No snoop or data is sent.
- R10: Counting the accept edge as cycle 1, results are due as follows. For a read without a snoop: beats in cycles 3+MEM_LAT and 4+MEM_LAT, completion in 5+MEM_LAT. For a read with a snoop: snoop in cycle 2; if the accepted response is driven in cycle r, beats follow in r+2+MEM_LAT and r+3+MEM_LAT and the completion in r+4+MEM_LAT. For a release: completion in cycle 2.
- R11: The completion is a single-cycle pulse that carries the requester's number and the line's resulting state code (0 Invalid, 1 Shared, 2 Exclusive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_agent_i | input | $clog2(N_AG) | Requesting agent number |
| req_op_i | input | 2 | Opcode: 1 release, otherwise read |
| req_addr_i | input | LINE_AW | Line index within the slice |
| snp_valid_o | output | 1 | Snoop valid |
| snp_tgt_o | output | N_AG | One-hot snoop target mask |
| snp_addr_o | output | LINE_AW | Line being snooped |
| snp_rsp_valid_i | input | 1 | Snoop response valid |
| snp_rsp_agent_i | input | $clog2(N_AG) | Agent sending the response |
| dat_valid_o | output | 1 | Data beat valid |
| dat_agent_o | output | $clog2(N_AG) | Agent receiving the data |
| dat_beat_o | output | $clog2(LINE_BYTES/BEAT_BYTES) | Beat index within the line |
| dat_data_o | output | DATA_W | Beat payload |
| cpl_valid_o | output | 1 | Completion pulse |
| cpl_agent_o | output | $clog2(N_AG) | Agent the completion is for |
| cpl_state_o | output | 2 | Resulting directory state of the line |

## Verification
Every result has a fixed cycle offset from the accept edge: the snoop in cycle 2, the beats and completion at the R10 offsets, and the return of ready one cycle after the completion. The bench counts falling edges from that accept edge and, for each result, records the cycle in which it appears next to its value. It then compares each cycle number with the offset computed from MEM_LAT and from the cycle in which the bench itself drove the owner's response. Snoop responses are sent with varying delays, sometimes preceded by a decoy response from the wrong agent, so the expected cycles move from one transaction to the next.

// File: rtl/hm_pkg.sv
package hm_pkg;
  typedef enum logic [1:0] {
    DIR_I = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2
  } dir_state_e;

  localparam logic [1:0] OP_RELEASE = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_SNP,
    ST_WAIT,
    ST_MEM,
    ST_DATA,
    ST_CPL
  } fsm_e;
endpackage

// File: rtl/hm_dir_array.sv
module hm_dir_array import hm_pkg::*; #(
  parameter int N_AG    = 4,
  parameter int LINE_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LINE_AW-1:0] rd_addr_i,
  output dir_state_e         rd_state_o,
  output logic [N_AG-1:0]    rd_pres_o,
  input  logic               wr_en_i,
  input  logic [LINE_AW-1:0] wr_addr_i,
  input  dir_state_e         wr_state_i,
  input  logic [N_AG-1:0]    wr_pres_i
);
  localparam int DEPTH = 1 << LINE_AW;

  dir_state_e      state_q [DEPTH];
  logic [N_AG-1:0] pres_q  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[i] <= DIR_I;
        pres_q[i]  <= '0;
      end else if (wr_en_i && wr_addr_i == LINE_AW'(i)) begin
        state_q[i] <= wr_state_i;
        pres_q[i]  <= wr_pres_i;
      end
    end
  end

  assign rd_state_o = state_q[rd_addr_i];
  assign rd_pres_o  = pres_q[rd_addr_i];

  // R9
  entry_consistent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ((wr_state_i == DIR_I) == (wr_pres_i == '0)));
endmodule

// File: rtl/hm_dir_policy.sv
module hm_dir_policy import hm_pkg::*; #(
  parameter int N_AG = 4,
  parameter int AG_W = 2
) (
  input  dir_state_e      cur_state_i,
  input  logic [N_AG-1:0] cur_pres_i,
  input  logic [AG_W-1:0] req_agent_i,
  input  logic            release_i,
  output logic            need_snp_o,
  output logic [N_AG-1:0] snp_mask_o,
  output dir_state_e      nxt_state_o,
  output logic [N_AG-1:0] nxt_pres_o
);
  logic [N_AG-1:0] req_bit;
  logic [N_AG-1:0] kept;

  assign req_bit = N_AG'(1) << req_agent_i;
  assign kept    = cur_pres_i & ~req_bit;

  always_comb begin
    need_snp_o  = 1'b0;
    snp_mask_o  = '0;
    nxt_state_o = cur_state_i;
    nxt_pres_o  = cur_pres_i;
    if (release_i) begin
      if ((cur_pres_i & req_bit) != '0) begin
        nxt_pres_o  = kept;
        nxt_state_o = (kept == '0) ? DIR_I : cur_state_i;
      end
    end else begin
      unique case (cur_state_i)
        DIR_S: nxt_pres_o = cur_pres_i | req_bit;
        DIR_E: begin
          if (cur_pres_i != req_bit) begin
            need_snp_o  = 1'b1;
            snp_mask_o  = cur_pres_i;
            nxt_state_o = DIR_S;
            nxt_pres_o  = cur_pres_i | req_bit;
          end
        end
        default: begin
          nxt_state_o = DIR_E;
          nxt_pres_o  = req_bit;
        end
      endcase
    end
  end
endmodule

// File: rtl/hm_mem_model.sv
module hm_mem_model #(
  parameter int LINE_AW = 4,
  parameter int DATA_W  = 32,
  parameter int MEM_LAT = 3,
  parameter int BEATS   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [LINE_AW-1:0]         addr_i,
  output logic                       beat_valid_o,
  output logic [$clog2(BEATS)-1:0]   beat_idx_o,
  output logic [DATA_W-1:0]          beat_data_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int LAST   = MEM_LAT + BEATS - 1;
  localparam int CNT_W  = $clog2(LAST + 1);
  localparam logic [DATA_W-1:0] MIX = DATA_W'(32'h9E3779B1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LINE_AW-1:0] addr_q;
  logic [DATA_W-1:0]  seed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      addr_q <= addr_i;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(LAST)) busy_q <= 1'b0;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign beat_valid_o = busy_q && (cnt_q >= CNT_W'(MEM_LAT));
  assign beat_idx_o   = BEAT_W'(cnt_q - CNT_W'(MEM_LAT));
  assign seed         = DATA_W'({addr_q, beat_idx_o}) + DATA_W'(1);
  assign beat_data_o  = seed * MIX;

  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/hm_home_agent.sv
module hm_home_agent import hm_pkg::*; #(
  parameter int N_AG       = 4,
  parameter int LINE_AW    = 4,
  parameter int DATA_W     = 32,
  parameter int MEM_LAT    = 3,
  parameter int LINE_BYTES = 128,
  parameter int BEAT_BYTES = 64
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      req_valid_i,
  output logic                                      req_ready_o,
  input  logic [$clog2(N_AG)-1:0]                   req_agent_i,
  input  logic [1:0]                                req_op_i,
  input  logic [LINE_AW-1:0]                        req_addr_i,
  output logic                                      snp_valid_o,
  output logic [N_AG-1:0]                           snp_tgt_o,
  output logic [LINE_AW-1:0]                        snp_addr_o,
  input  logic                                      snp_rsp_valid_i,
  input  logic [$clog2(N_AG)-1:0]                   snp_rsp_agent_i,
  output logic                                      dat_valid_o,
  output logic [$clog2(N_AG)-1:0]                   dat_agent_o,
  output logic [$clog2(LINE_BYTES/BEAT_BYTES)-1:0]  dat_beat_o,
  output logic [DATA_W-1:0]                         dat_data_o,
  output logic                                      cpl_valid_o,
  output logic [$clog2(N_AG)-1:0]                   cpl_agent_o,
  output logic [1:0]                                cpl_state_o
);
  localparam int AG_W   = $clog2(N_AG);
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W = $clog2(BEATS);

  fsm_e               st_q, st_d;
  logic [AG_W-1:0]    agent_q;
  logic               rel_q;
  logic [LINE_AW-1:0] addr_q;
  logic               accept;

  dir_state_e         dir_state, nxt_state;
  logic [N_AG-1:0]    dir_pres, nxt_pres, snp_mask;
  logic               need_snp;

  logic               mem_valid;
  logic [BEAT_W-1:0]  mem_beat;
  logic [DATA_W-1:0]  mem_data;

  assign accept = req_valid_i && req_ready_o;

  hm_dir_array #(.N_AG(N_AG), .LINE_AW(LINE_AW)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (addr_q),
    .rd_state_o (dir_state),
    .rd_pres_o  (dir_pres),
    .wr_en_i    (st_q == ST_CPL),
    .wr_addr_i  (addr_q),
    .wr_state_i (nxt_state),
    .wr_pres_i  (nxt_pres)
  );

  hm_dir_policy #(.N_AG(N_AG), .AG_W(AG_W)) u_policy (
    .cur_state_i (dir_state),
    .cur_pres_i  (dir_pres),
    .req_agent_i (agent_q),
    .release_i   (rel_q),
    .need_snp_o  (need_snp),
    .snp_mask_o  (snp_mask),
    .nxt_state_o (nxt_state),
    .nxt_pres_o  (nxt_pres)
  );

  hm_mem_model #(.LINE_AW(LINE_AW), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT), .BEATS(BEATS)) u_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (st_q == ST_MEM),
    .addr_i       (addr_q),
    .beat_valid_o (mem_valid),
    .beat_idx_o   (mem_beat),
    .beat_data_o  (mem_data)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = ST_DECIDE;
      ST_DECIDE: begin
        if (rel_q)         st_d = ST_CPL;
        else if (need_snp) st_d = ST_SNP;
        else               st_d = ST_MEM;
      end
      ST_SNP:    st_d = ST_WAIT;
      // only the recorded holder's answer releases the wait
      ST_WAIT:   if (snp_rsp_valid_i && snp_mask[snp_rsp_agent_i]) st_d = ST_MEM;
      ST_MEM:    st_d = ST_DATA;
      ST_DATA:   if (mem_valid && mem_beat == BEAT_W'(BEATS - 1)) st_d = ST_CPL;
      ST_CPL:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      agent_q <= '0;
      rel_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        agent_q <= req_agent_i;
        rel_q   <= (req_op_i == OP_RELEASE);
        addr_q  <= req_addr_i;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign snp_valid_o = (st_q == ST_SNP);
  assign snp_tgt_o   = snp_valid_o ? snp_mask : '0;
  assign snp_addr_o  = addr_q;
  assign dat_valid_o = (st_q == ST_DATA) && mem_valid;
  assign dat_agent_o = agent_q;
  assign dat_beat_o  = mem_beat;
  assign dat_data_o  = mem_data;
  assign cpl_valid_o = (st_q == ST_CPL);
  assign cpl_agent_o = agent_q;
  assign cpl_state_o = nxt_state;

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  // R6
  snp_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> ((snp_tgt_o & ~dir_pres) == '0) && ($countones(snp_tgt_o) == 1));

  // R4
  snp_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_o |-> (dir_state == DIR_E) && !dir_pres[agent_q]);

  // R7
  beat_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_valid_o && dat_beat_o == '0) |=> (dat_valid_o && dat_beat_o == BEAT_W'(1)));

  // R11
  cpl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o |=> (!cpl_valid_o && req_ready_o));
endmodule

// File: tb/hm_home_agent_tb.sv
`timescale 1ns/1ps
module hm_home_agent_tb_top;
  localparam int N_AG = 4;
  localparam int LINE_AW = 4;
  localparam int DATA_W = 32;
  localparam int MEM_LAT = 3;
  localparam int DEPTH = 1 << LINE_AW;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_agent = 0;
  logic [1:0] req_op = 0;
  logic [LINE_AW-1:0] req_addr = 0;
  logic rsp_valid = 0;
  logic [1:0] rsp_agent = 0;

  logic req_ready, snp_valid, dat_valid, cpl_valid;
  logic [N_AG-1:0] snp_tgt;
  logic [LINE_AW-1:0] snp_addr;
  logic [1:0] dat_agent, cpl_agent, cpl_state;
  logic [0:0] dat_beat;
  logic [DATA_W-1:0] dat_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int m_state [DEPTH];
  int m_pres [DEPTH];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  hm_home_agent #(.N_AG(N_AG), .LINE_AW(LINE_AW), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_agent_i(req_agent),
    .req_op_i(req_op), .req_addr_i(req_addr),
    .snp_valid_o(snp_valid), .snp_tgt_o(snp_tgt), .snp_addr_o(snp_addr),
    .snp_rsp_valid_i(rsp_valid), .snp_rsp_agent_i(rsp_agent),
    .dat_valid_o(dat_valid), .dat_agent_o(dat_agent), .dat_beat_o(dat_beat), .dat_data_o(dat_data),
    .cpl_valid_o(cpl_valid), .cpl_agent_o(cpl_agent), .cpl_state_o(cpl_state)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] beat_val(input int a, input int b);
    logic [DATA_W-1:0] s;
    s = DATA_W'(2 * a + b + 1);
    return s * 32'h9E3779B1;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_txn(input int ag, input int op, input int ad, input bit wrong, input int dly);
    int st, pr, owner, bitv, exp_st, exp_pr;
    bit rel, exp_snp, fin;
    int snp_n, snp_seen_tgt, nsnp, rsp_n, wrong_n, nb, cpl_n, cst, cag, ready_hi;
    int b_n [2];
    logic [DATA_W-1:0] b_d [2];
    int b_ag [2];
    string tag;
    st = m_state[ad]; pr = m_pres[ad]; bitv = 1 << ag; rel = (op == 1);
    owner = 0;
    for (int i = 0; i < N_AG; i++) if (pr[i]) owner = i;
    exp_snp = 0; exp_st = st; exp_pr = pr;
    if (rel) begin
      tag = "R9";
      if ((pr & bitv) != 0) begin
        exp_pr = pr & ~bitv;
        exp_st = (exp_pr == 0) ? 0 : st;
      end
    end else if (st == 0) begin
      tag = "R2"; exp_st = 2; exp_pr = bitv;
    end else if (st == 1) begin
      tag = "R3"; exp_pr = pr | bitv;
    end else if (pr == bitv) begin
      tag = "R5";
    end else begin
      tag = "R4"; exp_snp = 1; exp_st = 1; exp_pr = pr | bitv;
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_agent = 2'(ag); req_op = 2'(op); req_addr = LINE_AW'(ad);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    fin = 0; nsnp = 0; snp_n = 0; snp_seen_tgt = 0; rsp_n = -1; wrong_n = -1;
    nb = 0; cpl_n = 0; cst = 0; cag = 0; ready_hi = 0;
    for (int n = 1; n <= 80 && !fin; n++) begin
      if (n > 1) @(negedge clk);
      rsp_valid = 0;
      if (req_ready) ready_hi++;
      if (snp_valid) begin
        nsnp++; snp_n = n; snp_seen_tgt = int'(snp_tgt);
        wrong_n = wrong ? n + 1 : -1;
        rsp_n = n + 1 + (wrong ? 1 : 0) + dly;
      end
      if (n == wrong_n) begin rsp_valid = 1; rsp_agent = 2'(ag); end
      if (n == rsp_n)   begin rsp_valid = 1; rsp_agent = 2'(owner); end
      if (dat_valid) begin
        if (nb < 2) begin
          b_n[nb] = n; b_d[nb] = dat_data; b_ag[nb] = int'(dat_agent);
          chk(int'(dat_beat) == nb, "R7 beat index", dat_beat, nb);
        end
        nb++;
      end
      if (cpl_valid) begin
        cpl_n = n; cst = int'(cpl_state); cag = int'(cpl_agent); fin = 1;
      end
    end
    rsp_valid = 0;
    @(negedge clk);
    chk(req_ready == 1, "R8 ready after completion", req_ready, 1);
    chk(ready_hi == 0, "R8 ready low while busy", ready_hi, 0);
    chk(nsnp == (exp_snp ? 1 : 0), {tag, " snoop count"}, nsnp, exp_snp);
    if (exp_snp) begin
      chk(snp_seen_tgt == pr, "R6 snoop target", snp_seen_tgt, pr);
      chk(snp_n == 2, "R10 snoop cycle", snp_n, 2);
    end
    chk(cst == exp_st, {tag, " resulting state"}, cst, exp_st);
    chk(cag == ag, "R11 completion agent", cag, ag);
    if (rel) begin
      chk(nb == 0, "R9 no data on release", nb, 0);
      chk(cpl_n == 2, "R10 release completion cycle", cpl_n, 2);
    end else begin
      int r;
      r = exp_snp ? rsp_n : 1;
      chk(nb == 2, "R7 beat count", nb, 2);
      if (nb == 2) begin
        for (int b = 0; b < 2; b++) begin
          chk(b_d[b] == beat_val(ad, b), "R7 beat data", b_d[b], beat_val(ad, b));
          chk(b_ag[b] == ag, "R7 beat agent", b_ag[b], ag);
          chk(b_n[b] == r + 2 + MEM_LAT + b, "R10 beat cycle", b_n[b], r + 2 + MEM_LAT + b);
        end
      end
      chk(cpl_n == r + 4 + MEM_LAT, "R10 completion cycle", cpl_n, r + 4 + MEM_LAT);
    end
    m_state[ad] = exp_st; m_pres[ad] = exp_pr;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_state[i] = 0; m_pres[i] = 0; end
    #12 rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(!snp_valid && !dat_valid && !cpl_valid, "R1 valids low",
        {snp_valid, dat_valid, cpl_valid}, 0);
    // R1 and R2: every line starts Invalid, first read snoops nobody
    for (int a = 0; a < DEPTH; a++) do_txn(a % N_AG, 0, a, 0, 0);
    // R4: owner snoop with a decoy response first
    do_txn(1, 0, 0, 1, 2);
    do_txn(2, 0, 0, 0, 0);        // R3
    do_txn(1, 0, 1, 0, 0);        // R5
    do_txn(3, 1, 0, 0, 0);        // R9 non-holder release
    do_txn(0, 1, 0, 0, 0);        // R9 partial
    do_txn(1, 1, 0, 0, 0);
    do_txn(2, 1, 0, 0, 0);        // R9 last holder -> Invalid
    do_txn(3, 0, 0, 0, 0);        // R2 again
    // mixed sweep
    for (int k = 0; k < 300; k++) begin
      int ag, ad, op, dly;
      bit wr;
      step_lfsr();
      ag = int'(lfsr[1:0]); ad = int'(lfsr[7:4]);
      op = (lfsr[9:8] == 2'b00) ? 1 : (lfsr[10] ? 2 : 0);
      wr = lfsr[11]; dly = int'(lfsr[13:12]);
      do_txn(ag, op, ad, wr, dly);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule